// File: doc/BRIEF.md
# Masked Interrupt Control Register

This block gathers five one-cycle event pulses from neighbouring logic: an underflow from each of two interval timers, an alarm from the time-of-day clock, completion of the serial shift register, and an edge on an external flag pin. Each pulse sets a sticky flag. An enable mask decides which flags may raise the interrupt request to the processor. The block keeps the flags, the mask and the request line.

The processor sees one byte-wide register at a fixed offset in a 16-entry register map, and both of its access types have side effects. A write is a command. Bit 7 selects whether the mask bits named in bits 4..0 are set or cleared, and all other mask bits keep their value. A read returns the flags and a summary bit, then clears every flag, which drops the request. An event that arrives in the same cycle as a read appears in the byte being read. It is cleared together with the other flags, so it never raises the request line.

Top module: `intr_mask_reg`

## Requirements
- R1: After reset, all flags and all mask bits are 0, the interrupt output is low, and a read of the register returns 0x00.
- R2: Flag bit positions in the read byte are: bit 0 timer A underflow, bit 1 timer B underflow, bit 2 time-of-day alarm, bit 3 serial register done, bit 4 external flag. Bits 6 and 5 always read 0. The source input `srcPulse[i]` sets flag bit i.
- R3: A write to offset 13 with data bit 7 = 1 sets every mask bit i (i in 0..4) whose data bit i is 1. The other mask bits keep their value.
- R4: A write to offset 13 with data bit 7 = 0 clears every mask bit i whose data bit i is 1. The other mask bits keep their value.
- R5: A source pulse sets its flag whether or not its mask bit is set. While the mask bit is clear, the interrupt output stays low.
- R6: During a read of offset 13, `rdData` bit 7 is 1 exactly when some flag bit is set together with its mask bit. The value is shown in that same cycle.
- R7: After the clock edge that ends a read of offset 13, all flags are 0 and the interrupt output is low.
- R8: A pulse on a source whose mask bit is set raises the interrupt output at the clock edge that ends the pulse cycle.
- R9: A mask write that enables an already pending flag raises the interrupt output at the clock edge that ends the write cycle.
- R10: A source pulse in the same cycle as a read of offset 13 is shown in the byte being read. It is then cleared and does not raise the interrupt output.
- R11: Reads and writes to any offset other than 13 leave flags, mask and interrupt output unchanged. `rdData` is 0x00 whenever no read of offset 13 is in progress.
- R12: Clearing the mask bit of the only enabled pending flag drops the interrupt output at the end of the write cycle. The flag itself stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regAddr | input | 4 | Register offset of the current access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data; bit 7 selects set or clear |
| srcPulse | input | 5 | One-cycle event pulses, one per source |
| rdData | output | 8 | Read data: summary bit 7, flags in bits 4..0 |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
Every flag and mask bit can be seen at the ports. A wrong flag shows up in the next read byte, and a wrong mask bit shows up on `irqOut` one edge after the affected flag is set. If a flag or mask bit is lost or stuck, the interrupt output differs from the reference on the first cycle in which that bit matters. A fault in clear-on-read or in the same-cycle race leaves a nonzero byte on the following read or a high `irqOut` after the read edge. The reference model is compared with the outputs on every cycle, so such a fault is caught within one clock.

// File: rtl/icr_pkg.sv
package icr_pkg;

  // Strobes passed from the access decoder to the register datapath
  typedef struct packed {
    logic maskWr;   // write to this register this cycle
    logic maskSet;  // 1: set selected mask bits, 0: clear them
    logic flagRd;   // read of this register this cycle
  } icrStrobe_t;

endpackage

// File: rtl/icr_ctrl.sv
module icr_ctrl
  import icr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 13
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              setClrBit,
  output icrStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic addrHit;

  assign addrHit = (regAddr == HIT_ADDR);

  always_comb begin
    strobe         = '0;
    strobe.maskWr  = wrEn & addrHit;
    strobe.maskSet = setClrBit;
    strobe.flagRd  = rdEn & addrHit;
  end

endmodule

// File: rtl/icr_datapath.sv
module icr_datapath
  import icr_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  icrStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] maskBits,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  localparam int SUM_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] flagNext;
  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] flagSeen;
  logic               irqQ;

  // Flags as visible this cycle, including events that land now
  assign flagSeen = flagQ | srcPulse;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign flagNext[i] = strobe.flagRd ? 1'b0 : flagSeen[i];
    always_comb begin
      maskNext[i] = maskQ[i];
      if (strobe.maskWr && maskBits[i]) maskNext[i] = strobe.maskSet;
    end

    // R5: any pulse outside a read leaves its flag set
    a_r5_flag_latch: assert property (@(posedge clk) disable iff (!rstN)
      (srcPulse[i] && !strobe.flagRd) |=> flagQ[i]);
    // R11: mask only moves on a decoded write
    a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.maskWr |=> $stable(maskQ[i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      flagQ <= flagNext;
      maskQ <= maskNext;
      irqQ  <= |(flagNext & maskNext);
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.flagRd) begin
      rdData[NUM_SRC-1:0] = flagSeen;
      rdData[SUM_BIT]     = |(flagSeen & maskQ);
    end
  end

  assign irqOut = irqQ;

  // R7: a read leaves no flag behind
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagRd |=> (flagQ == '0));
  // R10: a read cycle never leaves the request raised
  a_r10_race_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagRd |=> !irqOut);
  // R8: an enabled event outside a read raises the request
  a_r8_event_irq: assert property (@(posedge clk) disable iff (!rstN)
    ((|(srcPulse & maskQ)) && !strobe.flagRd && !strobe.maskWr) |=> irqOut);
  // R3: set command leaves selected bits set
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskWr && strobe.maskSet) |=> ((maskQ & $past(maskBits)) == $past(maskBits)));
  // R4: clear command leaves selected bits clear
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskWr && !strobe.maskSet) |=> ((maskQ & $past(maskBits)) == '0));
  // R12: request follows the registered flag and mask state
  a_r12_irq_track: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(flagQ & maskQ)));

endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg
  import icr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int NUM_SRC    = 5,
  parameter int REG_OFFSET = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  localparam int CMD_BIT = DATA_W - 1;

  icrStrobe_t strobe;

  icr_ctrl #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) ctrl_i (
    .regAddr  (regAddr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .setClrBit(wrData[CMD_BIT]),
    .strobe   (strobe)
  );

  icr_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .maskBits(wrData[NUM_SRC-1:0]),
    .srcPulse(srcPulse),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/intr_mask_reg_tb_top.sv
`timescale 1ns/1ps
module intr_mask_reg_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [4:0] srcPulse = '0;
  logic [7:0] rdData;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int refFlag = 0;
  int refMask = 0;
  int refIrq = 0;

  always #4 clk = ~clk;

  intr_mask_reg dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .srcPulse(srcPulse), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, check read data, clock, check irq
  task automatic step(input string req, input int addr, input bit wr, input bit rd,
                      input int data, input int src);
    int seen;
    int expRd;
    bit hit;
    regAddr = 4'(addr); wrEn = wr; rdEn = rd; wrData = 8'(data); srcPulse = 5'(src);
    hit = (addr == 13);
    seen = refFlag | src;
    expRd = 0;
    if (rd && hit) expRd = seen | ((((seen & refMask) != 0)) ? 8'h80 : 0);
    #1;
    check(req, int'(rdData), expRd, "rdData");
    @(posedge clk);
    refFlag = (rd && hit) ? 0 : seen;
    if (wr && hit) begin
      if (data & 8'h80) refMask = refMask | (data & 8'h1f);
      else              refMask = refMask & ~(data & 8'h1f);
    end
    refIrq = ((refFlag & refMask) != 0) ? 1 : 0;
    @(negedge clk);
    regAddr = '0; wrEn = 1'b0; rdEn = 1'b0; wrData = '0; srcPulse = '0;
    check(req, int'(irqOut), refIrq, "irqOut");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", int'(irqOut), 0, "irqOut after reset");
    step("R1", 13, 0, 1, 0, 0);             // empty read
    step("R5", 0, 0, 0, 0, 5'h01);          // masked event latches
    step("R2", 13, 0, 1, 0, 0);             // reads 0x01
    step("R7", 13, 0, 1, 0, 0);             // cleared
    step("R3", 13, 1, 0, 8'h81, 0);         // enable bit 0
    step("R8", 0, 0, 0, 0, 5'h01);          // irq rises
    step("R6", 13, 0, 1, 0, 0);             // reads 0x81, irq drops
    step("R5", 0, 0, 0, 0, 5'h08);          // serial flag, masked
    step("R9", 13, 1, 0, 8'h88, 0);         // enabling pending flag
    step("R12", 13, 1, 0, 8'h08, 0);        // clear mask bit 3
    step("R4", 13, 0, 0, 0, 0);             // idle, flag stays
    step("R3", 13, 1, 0, 8'h82, 0);         // enable bit 1
    step("R10", 13, 0, 1, 0, 5'h02);        // race: reads 0x8a, irq low
    step("R10", 13, 0, 1, 0, 0);            // nothing kept
    step("R11", 12, 1, 0, 8'h9f, 5'h04);    // other address write
    step("R11", 14, 0, 1, 0, 0);            // other address read
    step("R11", 13, 0, 1, 0, 0);            // flag 2 still there
    step("R4", 13, 1, 0, 8'h03, 0);         // clear bits 0,1
    step("R3", 13, 1, 0, 8'h9f, 0);         // enable all
    step("R2", 0, 0, 0, 0, 5'h1f);          // all sources
    step("R2", 13, 0, 1, 0, 0);             // reads 0x9f
    step("R8", 0, 0, 0, 0, 5'h10);          // external flag
    step("R12", 13, 1, 0, 8'h10, 5'h00);    // mask off, flag held
    step("R9", 13, 1, 0, 8'h90, 0);         // re-enable
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    refFlag = 0; refMask = 0; refIrq = 0;
    check("R1", int'(irqOut), 0, "irqOut after second reset");
    step("R1", 0, 0, 0, 0, 5'h01);          // mask cleared by reset
    step("R1", 13, 0, 1, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule